// File: doc/BRIEF.md
# Programming Command Length Guard

This block sits next to a three-wire serial memory command decoder and stops a damaged programming command from reaching the storage array. While select is high, it counts the serial clock rising edges, starting with the edge that carried the start bit. When select falls, it compares that count with the exact frame length that the decoded instruction class and the current organisation call for. A programming command (write, erase, erase-all, write-all) of the right length produces a one-cycle execute strobe. A programming command whose length is wrong by any amount produces a one-cycle abort strobe instead, and the array is not touched.

One extra clock glitch moves every address and data bit along by one position, so that frame is exactly one pulse too long. The length check catches it. Read, enable and disable commands pass through ungated. All inputs are already synchronous to the system clock: a select level, a one-cycle pulse per serial clock rising edge, a one-cycle start-bit pulse, a class code held by the decoder until select falls, and the organisation level.

Top module: `mwg_len_guard`

## Requirements
- R1: After reset both strobes are low. A select fall with no start bit seen since select rose gives no strobe.
- R2: In narrow organisation (`org_wide`=0), a write (class 4) with exactly 20 counted pulses gives an execute strobe.
- R3: In wide organisation (`org_wide`=1), a write (class 4) with exactly 27 counted pulses gives an execute strobe.
- R4: An erase (class 5) needs exactly 12 pulses in narrow and 11 pulses in wide organisation.
- R5: An erase-all (class 6) carries dummy address bits and needs the same count as an erase: 12 in narrow and 11 in wide organisation.
- R6: A write-all (class 7) needs exactly 20 pulses in narrow and 27 pulses in wide organisation.
- R7: A programming class whose count differs from its required count by any amount, including one glitch pulse more or one pulse less, gives an abort strobe and no execute strobe.
- R8: The pulse counter saturates at 2^CNT_W-1 (31 by default) and does not wrap. A programming burst of 100 pulses still aborts.
- R9: Read (class 1), enable (class 2) and disable (class 3) give an execute strobe at the select fall whatever the count. They never abort.
- R10: Each strobe is one system clock wide. It is set at the first clock edge that samples select low after it was high. Execute and abort never occur together.
- R11: Pulses seen before the start bit are not counted. The start-bit pulse counts as 1. A new start bit while select is high restarts the count at 1.
- R12: Class 0 (no decoded instruction) gives no strobe at all.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Synchronised chip select level |
| sclk_rise | input | 1 | One-cycle pulse per serial clock rising edge |
| start_hit | input | 1 | One-cycle pulse, coincident with the serial clock pulse that carried the start bit |
| cmd_class | input | 3 | Decoded class: 0 none, 1 read, 2 enable, 3 disable, 4 write, 5 erase, 6 erase-all, 7 write-all |
| org_wide | input | 1 | 1 selects 16-bit words, 0 selects 8-bit bytes |
| exec_stb | output | 1 | One-cycle strobe: perform the command |
| abort_stb | output | 1 | One-cycle strobe: programming command rejected |

## Verification
Every class code is swept in both organisations with frame lengths from 0 to 35 pulses. The sweep shows that each programming class accepts exactly one length and that the accepted length depends on both the class and the organisation, while the ungated classes accept every length. Separate frames add stray pulses before the start bit, insert a second start bit part-way through the frame, and run bursts past the counter's range. These show that the count origin is the latest start bit and that the counter saturates rather than wrapping back onto a valid length.

// File: rtl/mwg_pkg.sv
package mwg_pkg;
   typedef enum logic [2:0] {
      CLS_NONE  = 3'd0,
      CLS_READ  = 3'd1,
      CLS_WEN   = 3'd2,
      CLS_WDIS  = 3'd3,
      CLS_WRITE = 3'd4,
      CLS_ERASE = 3'd5,
      CLS_ERALL = 3'd6,
      CLS_WRALL = 3'd7
   } cmd_cls_e;

   function automatic logic cls_is_prog(input logic [2:0] c);
      return c[2];
   endfunction

   function automatic logic cls_has_data(input logic [2:0] c);
      return (c == CLS_WRITE) || (c == CLS_WRALL);
   endfunction
endpackage

// File: rtl/mwg_edge_counter.sv
module mwg_edge_counter #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel,
   input  logic             edge_rise,
   input  logic             start_hit,
   output logic [CNT_W-1:0] cnt,
   output logic             armed
);
   localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   if (CNT_W < 2) begin : g_bad_width
      $error("mwg_edge_counter: CNT_W must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         armed <= 1'b0;
      end else if (!sel) begin
         cnt   <= '0;
         armed <= 1'b0;
      end else if (start_hit) begin
         cnt   <= ONE;
         armed <= 1'b1;
      end else if (armed && edge_rise) begin
         cnt <= (cnt == SAT) ? SAT : cnt + ONE;
      end
   end

   p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && !start_hit && armed && edge_rise && cnt == SAT) |=> (cnt == SAT));
   p_start_one_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (sel && start_hit) |=> (cnt == ONE && armed));
   p_idle_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!sel) |=> (cnt == '0 && !armed));
   p_no_count_unarmed_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!armed && !start_hit) |=> (cnt == '0));
endmodule

// File: rtl/mwg_len_table.sv
module mwg_len_table
   import mwg_pkg::*;
#(
   parameter int CNT_W    = 5,
   parameter int OPC_W    = 2,
   parameter int ADDR_WW  = 8,
   parameter int ADDR_WN  = 9,
   parameter int DATA_WW  = 16,
   parameter int DATA_WN  = 8,
   parameter int ORG_MODE = 0
) (
   input  logic             org_wide,
   input  logic [2:0]       cls,
   output logic [CNT_W-1:0] exp_len,
   output logic             gated,
   output logic             known
);
   localparam int HEAD    = 1 + OPC_W;
   localparam int SHORT_W = HEAD + ADDR_WW;
   localparam int SHORT_N = HEAD + ADDR_WN;
   localparam int LONG_W  = SHORT_W + DATA_WW;
   localparam int LONG_N  = SHORT_N + DATA_WN;
   localparam int MAX_LEN = (LONG_W > LONG_N) ? LONG_W : LONG_N;

   if (MAX_LEN >= (1 << CNT_W) - 1) begin : g_bad_range
      $error("mwg_len_table: CNT_W too small for longest frame");
   end
   if (ORG_MODE < 0 || ORG_MODE > 2) begin : g_bad_mode
      $error("mwg_len_table: ORG_MODE must be 0, 1 or 2");
   end

   logic wide_eff;
   if (ORG_MODE == 1) begin : g_fixed_narrow
      assign wide_eff = 1'b0;
   end else if (ORG_MODE == 2) begin : g_fixed_wide
      assign wide_eff = 1'b1;
   end else begin : g_pin_org
      assign wide_eff = org_wide;
   end

   always_comb begin
      if (cls_has_data(cls))
         exp_len = wide_eff ? CNT_W'(LONG_W) : CNT_W'(LONG_N);
      else
         exp_len = wide_eff ? CNT_W'(SHORT_W) : CNT_W'(SHORT_N);
      gated = cls_is_prog(cls);
      known = (cls != CLS_NONE);
   end
endmodule

// File: rtl/mwg_verdict.sv
module mwg_verdict #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel,
   input  logic             armed,
   input  logic [CNT_W-1:0] cnt,
   input  logic [CNT_W-1:0] exp_len,
   input  logic             gated,
   input  logic             known,
   output logic             exec_stb,
   output logic             abort_stb
);
   logic sel_q;
   logic fall;
   logic len_ok;

   assign fall   = sel_q && !sel;
   assign len_ok = (cnt == exp_len);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q     <= 1'b0;
         exec_stb  <= 1'b0;
         abort_stb <= 1'b0;
      end else begin
         sel_q     <= sel;
         exec_stb  <= fall && armed && known && (!gated || len_ok);
         abort_stb <= fall && armed && known && gated && !len_ok;
      end
   end

   p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(exec_stb && abort_stb));
   p_single_exec_r10: assert property (@(posedge clk) disable iff (!rst_n)
      exec_stb |=> !exec_stb);
   p_single_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
      abort_stb |=> !abort_stb);
   p_after_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && armed && known) |=> (exec_stb || abort_stb));
   p_abort_gated_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (fall && !gated) |=> !abort_stb);
   p_none_silent_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (!known) |=> !(exec_stb || abort_stb));
endmodule

// File: rtl/mwg_len_guard.sv
module mwg_len_guard #(
   parameter int OPC_W    = 2,
   parameter int ADDR_WW  = 8,
   parameter int ADDR_WN  = 9,
   parameter int DATA_WW  = 16,
   parameter int DATA_WN  = 8,
   parameter int CNT_W    = 5,
   parameter int ORG_MODE = 0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sel,
   input  logic       sclk_rise,
   input  logic       start_hit,
   input  logic [2:0] cmd_class,
   input  logic       org_wide,
   output logic       exec_stb,
   output logic       abort_stb
);
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] exp_len;
   logic             armed;
   logic             gated;
   logic             known;

   mwg_edge_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (sel),
      .edge_rise (sclk_rise),
      .start_hit (start_hit),
      .cnt       (cnt),
      .armed     (armed)
   );

   mwg_len_table #(
      .CNT_W    (CNT_W),
      .OPC_W    (OPC_W),
      .ADDR_WW  (ADDR_WW),
      .ADDR_WN  (ADDR_WN),
      .DATA_WW  (DATA_WW),
      .DATA_WN  (DATA_WN),
      .ORG_MODE (ORG_MODE)
   ) u_tab (
      .org_wide (org_wide),
      .cls      (cmd_class),
      .exp_len  (exp_len),
      .gated    (gated),
      .known    (known)
   );

   mwg_verdict #(.CNT_W(CNT_W)) u_ver (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (sel),
      .armed     (armed),
      .cnt       (cnt),
      .exp_len   (exp_len),
      .gated     (gated),
      .known     (known),
      .exec_stb  (exec_stb),
      .abort_stb (abort_stb)
   );

   p_quiet_sel_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(sel) && sel) |-> !(exec_stb || abort_stb));
endmodule

// File: tb/mwg_len_guard_test.sv
module mwg_len_guard_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       sel = 1'b0;
   logic       sclk_rise = 1'b0;
   logic       start_hit = 1'b0;
   logic [2:0] cmd_class = 3'd0;
   logic       org_wide = 1'b0;
   logic       exec_stb;
   logic       abort_stb;

   int total = 0;
   int bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   mwg_len_guard uut (
      .clk(clk), .rst_n(rst_n), .sel(sel), .sclk_rise(sclk_rise),
      .start_hit(start_hit), .cmd_class(cmd_class), .org_wide(org_wide),
      .exec_stb(exec_stb), .abort_stb(abort_stb)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   function automatic int req_len(input int c, input bit w);
      if (c == 4 || c == 7) return w ? 27 : 20;
      return w ? 11 : 12;
   endfunction

   task automatic pulse(input bit st);
      @(negedge clk);
      sclk_rise = 1'b1;
      start_hit = st;
      @(negedge clk);
      sclk_rise = 1'b0;
      start_hit = 1'b0;
   endtask

   // pre: pulses before start; n: pulses from start; rs: index of a second start (-1 none)
   task automatic run_cmd(input int c, input bit w, input int pre, input int n,
                          input int rs, output int ne, output int na, output int both);
      ne = 0; na = 0; both = 0;
      @(negedge clk);
      cmd_class = 3'(c);
      org_wide  = w;
      sel       = 1'b1;
      @(negedge clk);
      for (int i = 0; i < pre; i++) pulse(1'b0);
      for (int i = 0; i < n; i++) pulse(i == 0 || i == rs);
      @(negedge clk);
      sel = 1'b0;
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         if (exec_stb) ne++;
         if (abort_stb) na++;
         if (exec_stb && abort_stb) both++;
      end
      repeat (2) @(negedge clk);
   endtask

   initial begin
      int ne, na, both, ee, ea;
      string tag;
      repeat (3) @(negedge clk);
      chk(exec_stb == 0 && abort_stb == 0, "R1 reset", exec_stb + abort_stb, 0);
      rst_n = 1'b1;
      // R1: select toggled with pulses but no start bit
      run_cmd(4, 0, 20, 0, -1, ne, na, both);
      chk(ne + na == 0, "R1 no start", ne + na, 0);

      for (int w = 0; w < 2; w++) begin
         for (int c = 0; c < 8; c++) begin
            for (int n = 0; n <= 35; n++) begin
               run_cmd(c, w[0], 0, n, -1, ne, na, both);
               ee = 0; ea = 0;
               if (n == 0 || c == 0) tag = (n == 0) ? "R11 no start" : "R12 none";
               else if (c < 4) begin ee = 1; tag = "R9 ungated"; end
               else if (n == req_len(c, w[0])) begin
                  ee = 1;
                  case (c)
                     4: tag = w ? "R3 write wide" : "R2 write narrow";
                     5: tag = "R4 erase";
                     6: tag = "R5 erase all";
                     default: tag = "R6 write all";
                  endcase
               end else begin ea = 1; tag = "R7 length mismatch"; end
               chk(ne == ee, {tag, " exec"}, ne, ee);
               chk(na == ea, {tag, " abort"}, na, ea);
               chk(both == 0 && ne <= 1 && na <= 1, "R10 single and exclusive", ne + na, ee + ea);
            end
         end
      end

      // R11: stray pulses before start are not counted
      run_cmd(4, 0, 5, 20, -1, ne, na, both);
      chk(ne == 1 && na == 0, "R11 pre-start pulses", ne, 1);
      // R11: restart count on a second start bit
      run_cmd(4, 1, 0, 33, 6, ne, na, both);
      chk(ne == 1 && na == 0, "R11 restart at second start", ne, 1);
      run_cmd(5, 0, 0, 14, 3, ne, na, both);
      chk(na == 1 && ne == 0, "R11 restart mismatch", na, 1);
      // R8: saturation never wraps onto a valid length
      run_cmd(4, 0, 0, 100, -1, ne, na, both);
      chk(na == 1 && ne == 0, "R8 long burst write", na, 1);
      run_cmd(5, 1, 0, 75, -1, ne, na, both);
      chk(na == 1 && ne == 0, "R8 wrap-to-valid erase", na, 1);
      run_cmd(2, 1, 0, 90, -1, ne, na, both);
      chk(ne == 1 && na == 0, "R9 long enable", ne, 1);

      done = 1'b1;
   end

   initial begin
      int cyc = 0;
      while (!done && cyc < 190000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) chk(1'b0, "watchdog", cyc, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule